// File: doc/BRIEF.md
# Byte-Packing SPI FIFO Pair

This block sits between a serial shift engine and a register bus. On the receive side it gathers the bytes coming off the wire into 32-bit entries, always four bytes to an entry, whatever word length the serial engine is set to. When a transfer ends with fewer than four bytes gathered, the partial word is still stored. The head entry then reports how many of its bytes are valid. On the transmit side it is a plain 32-bit FIFO that the bus fills and the shift engine drains.

Each direction has a control word with an enable, a write-one flush and a trigger level. The block raises a one-cycle request pulse when software should service a FIFO. A status word carries both fill levels, and a constant identification word reports both depths. Error pulses flag words lost to a full receive FIFO and words the shift engine asked for while the transmit FIFO was empty.

Top module: `spi_pack_fifo`

## Requirements
- R1: Four received bytes form one receive entry; the first byte received lands in bits [31:24] and the fourth in bits [7:0], and the head byte count then reads 4.
- R2: A frame-end strobe with 1 to 3 bytes gathered stores a partial entry. Its bytes are right-aligned with the oldest byte highest and unused upper bytes zero, the head byte count reads 1 to 3, and rxReq pulses once. A frame-end with nothing gathered stores nothing.
- R3: fifoStatus[5:0] is the receive fill level and fifoStatus[13:8] the transmit fill level, both in entries. rxHeadBytes reads 0 exactly when the receive FIFO is empty.
- R4: In each control word, bit 0 is enable and bit [13:8] is the trigger level. Bytes arriving while receive is disabled are dropped, and pushes while transmit is disabled are dropped.
- R5: Writing a control word with bit 1 set empties that FIFO in one cycle, including any bytes gathered toward a partial receive entry. The flush bit is not stored.
- R6: idWord holds the transmit depth at bits [29:24] and the receive depth at bits [21:16], with all other bits zero.
- R7: rxReq pulses for one cycle when the receive fill level rises from below the trigger level to at or above it. A trigger level of 0 leaves only the frame-end request.
- R8: txReq pulses for one cycle when the transmit fill level falls from above the trigger level to at or below it, including a fall caused by a flush.
- R9: A completed receive entry that finds the FIFO full is discarded; rxOverflow pulses and the stored entries are kept unchanged.
- R10: A txPop while txActive is high and the transmit FIFO is empty pulses txUnderflow. The same pop with txActive low does not.
- R11: Transmit entries leave in the order they were pushed, with txData showing the head entry. A push to a full transmit FIFO is dropped.
- R12: After reset both FIFOs are empty and disabled, both trigger levels are 0, and no pulse output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxCtrlWr | input | 1 | Write strobe for the receive control word |
| txCtrlWr | input | 1 | Write strobe for the transmit control word |
| ctrlWdata | input | 16 | Control word: bit 0 enable, bit 1 flush, [13:8] trigger level |
| rxByteValid | input | 1 | A received byte is present on rxByte |
| rxByte | input | 8 | Received byte from the shift engine |
| rxFrameEnd | input | 1 | End of transfer; stores any gathered bytes after this cycle's byte |
| rxPop | input | 1 | Remove the head receive entry |
| rxData | output | 32 | Head receive entry |
| rxHeadBytes | output | 3 | Valid bytes in the head receive entry, 0 when empty |
| txPush | input | 1 | Append txWdata to the transmit FIFO |
| txWdata | input | 32 | Transmit word from the bus |
| txPop | input | 1 | Shift engine takes the head transmit entry |
| txActive | input | 1 | Shift engine is mid-transfer |
| txData | output | 32 | Head transmit entry |
| fifoStatus | output | 16 | Fill levels: RX at [5:0], TX at [13:8] |
| idWord | output | 32 | Depths: TX at [29:24], RX at [21:16] |
| rxReq | output | 1 | Receive service request pulse |
| txReq | output | 1 | Transmit service request pulse |
| rxOverflow | output | 1 | Receive entry lost to a full FIFO |
| txUnderflow | output | 1 | Pop from an empty transmit FIFO while active |

## Verification
The bench targets the packing edges. A design that reversed the byte order would show the fourth byte in the top lane. One that left-aligned a partial word would put it above zero padding. One that treated a bare frame-end as a word would store an empty entry with a count of zero. The bench flushes with a byte half-gathered and then sends a full word: a packer that survives the flush would show a stale byte in the next entry. Request tests place the level exactly on the trigger from both directions, and also step past the trigger, which must not pulse again. This catches level-sensitive requests and comparisons that are off by one. The bench overfills the receive FIFO and then drains it, so a design that overwrote the oldest entry, or lost count, would show the wrong first or last word.

// File: rtl/spi_pack_fifo_pkg.sv
package spi_pack_fifo_pkg;
  // Width of every fill-level and trigger-level field.
  localparam int LVL_W = 6;

  // Strobes from control to datapath, all for the current cycle.
  typedef struct packed {
    logic packByte;  // shift rxByte into the packer
    logic packEmit;  // packer contents leave (stored or dropped)
    logic rxWrite;   // store the packer output in the RX FIFO
    logic rxRead;    // drop the RX head entry
    logic rxClear;   // flush RX FIFO and packer
    logic txWrite;   // store txWdata
    logic txRead;    // drop the TX head entry
    logic txClear;   // flush TX FIFO
  } fifoStrobes_t;
endpackage

// File: rtl/spi_pack_fifo_ram.sv
module spi_pack_fifo_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (wrEn) wrPtr <= bump(wrPtr);
      if (rdEn) rdPtr <= bump(rdPtr);
    end
  end

  assign rdData = mem[rdPtr];
endmodule

// File: rtl/spi_pack_fifo_dp.sv
module spi_pack_fifo_dp
  import spi_pack_fifo_pkg::*;
#(
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  fifoStrobes_t strobes,
  input  logic [7:0]   rxByte,
  input  logic [31:0]  txWdata,
  output logic [2:0]   packCnt,
  output logic [31:0]  rxData,
  output logic [2:0]   rxHeadCnt,
  output logic [31:0]  txData
);
  localparam int RX_W = 32 + 3;

  logic [31:0] packReg;
  logic [31:0] packNext;
  logic [2:0]  cntNext;
  logic [RX_W-1:0] rxHead;

  // Newest byte enters at the bottom, so older bytes sit higher.
  always_comb begin
    packNext = packReg;
    cntNext  = packCnt;
    if (strobes.packByte) begin
      packNext = {packReg[23:0], rxByte};
      cntNext  = packCnt + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      packReg <= '0;
      packCnt <= '0;
    end else if (strobes.rxClear || strobes.packEmit) begin
      packReg <= '0;
      packCnt <= '0;
    end else if (strobes.packByte) begin
      packReg <= packNext;
      packCnt <= cntNext;
    end
  end

  spi_pack_fifo_ram #(.DEPTH(RX_DEPTH), .WIDTH(RX_W)) rxRam_i (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (strobes.rxClear),
    .wrEn   (strobes.rxWrite),
    .wrData ({cntNext, packNext}),
    .rdEn   (strobes.rxRead),
    .rdData (rxHead)
  );

  spi_pack_fifo_ram #(.DEPTH(TX_DEPTH), .WIDTH(32)) txRam_i (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (strobes.txClear),
    .wrEn   (strobes.txWrite),
    .wrData (txWdata),
    .rdEn   (strobes.txRead),
    .rdData (txData)
  );

  assign rxData    = rxHead[31:0];
  assign rxHeadCnt = rxHead[RX_W-1:32];
endmodule

// File: rtl/spi_pack_fifo_ctrl.sv
module spi_pack_fifo_ctrl
  import spi_pack_fifo_pkg::*;
#(
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxCtrlWr,
  input  logic             txCtrlWr,
  input  logic [15:0]      ctrlWdata,
  input  logic             rxByteValid,
  input  logic             rxFrameEnd,
  input  logic             rxPop,
  input  logic             txPush,
  input  logic             txPop,
  input  logic             txActive,
  input  logic [2:0]       packCnt,
  output fifoStrobes_t     strobes,
  output logic [LVL_W-1:0] rxLevel,
  output logic [LVL_W-1:0] txLevel,
  output logic             rxReq,
  output logic             txReq,
  output logic             rxOverflow,
  output logic             txUnderflow
);
  localparam logic [LVL_W-1:0] RX_FULL = LVL_W'(RX_DEPTH);
  localparam logic [LVL_W-1:0] TX_FULL = LVL_W'(TX_DEPTH);

  logic rxEn, txEn;
  logic [LVL_W-1:0] rxTrig, txTrig;
  logic [LVL_W-1:0] rxLvlNext, txLvlNext;
  logic rxFlush, txFlush, byteIn, endIn, partialEmit;
  logic [2:0] nextCnt;
  logic unusedCtrlBits;

  assign unusedCtrlBits = ^{ctrlWdata[15:14], ctrlWdata[7:2]};

  assign rxFlush = rxCtrlWr & ctrlWdata[1];
  assign txFlush = txCtrlWr & ctrlWdata[1];
  assign byteIn  = rxEn & rxByteValid & ~rxFlush;
  assign endIn   = rxEn & rxFrameEnd & ~rxFlush;
  assign nextCnt = packCnt + {2'b00, byteIn};
  assign partialEmit = endIn && (nextCnt != 3'd0) && (nextCnt != 3'd4);

  always_comb begin
    strobes          = '0;
    strobes.packByte = byteIn;
    strobes.packEmit = (nextCnt == 3'd4) || partialEmit;
    strobes.rxWrite  = strobes.packEmit && (rxLevel != RX_FULL);
    strobes.rxRead   = rxPop && (rxLevel != '0) && !rxFlush;
    strobes.rxClear  = rxFlush;
    strobes.txWrite  = txEn && txPush && (txLevel != TX_FULL) && !txFlush;
    strobes.txRead   = txPop && (txLevel != '0) && !txFlush;
    strobes.txClear  = txFlush;
  end

  assign rxLvlNext = rxFlush ? '0 :
                     rxLevel + LVL_W'(strobes.rxWrite) - LVL_W'(strobes.rxRead);
  assign txLvlNext = txFlush ? '0 :
                     txLevel + LVL_W'(strobes.txWrite) - LVL_W'(strobes.txRead);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEn        <= 1'b0;
      txEn        <= 1'b0;
      rxTrig      <= '0;
      txTrig      <= '0;
      rxLevel     <= '0;
      txLevel     <= '0;
      rxReq       <= 1'b0;
      txReq       <= 1'b0;
      rxOverflow  <= 1'b0;
      txUnderflow <= 1'b0;
    end else begin
      if (rxCtrlWr) begin
        rxEn   <= ctrlWdata[0];
        rxTrig <= ctrlWdata[13:8];
      end
      if (txCtrlWr) begin
        txEn   <= ctrlWdata[0];
        txTrig <= ctrlWdata[13:8];
      end
      rxLevel     <= rxLvlNext;
      txLevel     <= txLvlNext;
      rxReq       <= (strobes.rxWrite && partialEmit) ||
                     ((rxLvlNext >= rxTrig) && (rxLevel < rxTrig));
      txReq       <= (txLvlNext <= txTrig) && (txLevel > txTrig);
      rxOverflow  <= strobes.packEmit && (rxLevel == RX_FULL);
      txUnderflow <= txPop && txActive && (txLevel == '0) && !txFlush;
    end
  end
endmodule

// File: rtl/spi_pack_fifo.sv
module spi_pack_fifo
  import spi_pack_fifo_pkg::*;
#(
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxCtrlWr,
  input  logic        txCtrlWr,
  input  logic [15:0] ctrlWdata,
  input  logic        rxByteValid,
  input  logic [7:0]  rxByte,
  input  logic        rxFrameEnd,
  input  logic        rxPop,
  output logic [31:0] rxData,
  output logic [2:0]  rxHeadBytes,
  input  logic        txPush,
  input  logic [31:0] txWdata,
  input  logic        txPop,
  input  logic        txActive,
  output logic [31:0] txData,
  output logic [15:0] fifoStatus,
  output logic [31:0] idWord,
  output logic        rxReq,
  output logic        txReq,
  output logic        rxOverflow,
  output logic        txUnderflow
);
  localparam logic [LVL_W-1:0] RX_SIZE = LVL_W'(RX_DEPTH);
  localparam logic [LVL_W-1:0] TX_SIZE = LVL_W'(TX_DEPTH);

  fifoStrobes_t strobes;
  logic [2:0] packCnt, rxHeadCnt;
  logic [LVL_W-1:0] rxLevel, txLevel;

  spi_pack_fifo_ctrl #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) ctrl_i (
    .clk, .rstN, .rxCtrlWr, .txCtrlWr, .ctrlWdata, .rxByteValid, .rxFrameEnd,
    .rxPop, .txPush, .txPop, .txActive, .packCnt, .strobes, .rxLevel, .txLevel,
    .rxReq, .txReq, .rxOverflow, .txUnderflow
  );

  spi_pack_fifo_dp #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) dp_i (
    .clk, .rstN, .strobes, .rxByte, .txWdata, .packCnt, .rxData, .rxHeadCnt,
    .txData
  );

  assign rxHeadBytes = (rxLevel == '0) ? 3'd0 : rxHeadCnt;
  assign fifoStatus  = {2'b00, txLevel, 2'b00, rxLevel};
  assign idWord      = {2'b00, TX_SIZE, 2'b00, RX_SIZE, 16'h0000};
endmodule

// File: rtl/spi_pack_fifo_chk.sv
module spi_pack_fifo_chk #(
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        rxCtrlWr,
  input logic        txCtrlWr,
  input logic [15:0] ctrlWdata,
  input logic        txPush,
  input logic        txPop,
  input logic        txActive,
  input logic [15:0] fifoStatus,
  input logic [2:0]  rxHeadBytes,
  input logic        rxOverflow,
  input logic        txUnderflow
);
  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoStatus[5:0] <= 6'(RX_DEPTH)) && (fifoStatus[13:8] <= 6'(TX_DEPTH)));

  // R3
  head_bytes_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoStatus[5:0] == 6'd0) == (rxHeadBytes == 3'd0));

  // R5
  rx_flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxCtrlWr && ctrlWdata[1]) |=> (fifoStatus[5:0] == 6'd0));

  // R9
  overflow_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxOverflow |-> ($past(fifoStatus[5:0]) == 6'(RX_DEPTH)));

  // R10
  underflow_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    txUnderflow |-> $past(txPop && txActive && (fifoStatus[13:8] == 6'd0)));

  // R11
  tx_level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txPush && !txPop && !txCtrlWr) |=> $stable(fifoStatus[13:8]));
endmodule

bind spi_pack_fifo spi_pack_fifo_chk #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .rxCtrlWr(rxCtrlWr), .txCtrlWr(txCtrlWr),
  .ctrlWdata(ctrlWdata), .txPush(txPush), .txPop(txPop), .txActive(txActive),
  .fifoStatus(fifoStatus), .rxHeadBytes(rxHeadBytes), .rxOverflow(rxOverflow),
  .txUnderflow(txUnderflow)
);

// File: tb/spi_pack_fifo_tb_top.sv
module spi_pack_fifo_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxCtrlWr = 0, txCtrlWr = 0;
  logic [15:0] ctrlWdata = '0;
  logic rxByteValid = 0, rxFrameEnd = 0, rxPop = 0;
  logic [7:0] rxByte = '0;
  logic txPush = 0, txPop = 0, txActive = 0;
  logic [31:0] txWdata = '0;
  logic [31:0] rxData, txData, idWord;
  logic [2:0]  rxHeadBytes;
  logic [15:0] fifoStatus;
  logic rxReq, txReq, rxOverflow, txUnderflow;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_pack_fifo #(.RX_DEPTH(8), .TX_DEPTH(4)) dut_i (
    .clk, .rstN, .rxCtrlWr, .txCtrlWr, .ctrlWdata, .rxByteValid, .rxByte,
    .rxFrameEnd, .rxPop, .rxData, .rxHeadBytes, .txPush, .txWdata, .txPop,
    .txActive, .txData, .fifoStatus, .idWord, .rxReq, .txReq, .rxOverflow,
    .txUnderflow
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ctrlWrite(input bit isRx, input logic [15:0] w);
    rxCtrlWr = isRx; txCtrlWr = !isRx; ctrlWdata = w;
    step();
    rxCtrlWr = 0; txCtrlWr = 0; ctrlWdata = '0;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit last);
    rxByteValid = 1; rxByte = b; rxFrameEnd = last;
    step();
    rxByteValid = 0; rxFrameEnd = 0;
  endtask

  task automatic popRx();
    rxPop = 1; step(); rxPop = 0;
  endtask

  task automatic pushTx(input logic [31:0] w);
    txPush = 1; txWdata = w; step(); txPush = 0;
  endtask

  task automatic popTx(input bit active);
    txPop = 1; txActive = active; step(); txPop = 0; txActive = 0;
  endtask

  task automatic t_reset();
    chk("R12 rx level", 32'(fifoStatus[5:0]), 0);
    chk("R12 tx level", 32'(fifoStatus[13:8]), 0);
    chk("R12 pulses", {28'd0, rxReq, txReq, rxOverflow, txUnderflow}, 0);
    chk("R6 id word", idWord, 32'h0408_0000);
    sendByte(8'h55, 0); sendByte(8'h56, 0); sendByte(8'h57, 0); sendByte(8'h58, 0);
    chk("R12 disabled rx after reset", 32'(fifoStatus[5:0]), 0);
  endtask

  task automatic t_pack();
    ctrlWrite(1, 16'h0001);
    sendByte(8'hA1, 0); sendByte(8'hA2, 0); sendByte(8'hA3, 0);
    chk("R1 no entry before fourth byte", 32'(fifoStatus[5:0]), 0);
    sendByte(8'hA4, 0);
    chk("R1 level", 32'(fifoStatus[5:0]), 1);
    chk("R1 data order", rxData, 32'hA1A2A3A4);
    chk("R1 byte count", 32'(rxHeadBytes), 4);
    popRx();
    chk("R3 empty after pop", 32'(rxHeadBytes), 0);
  endtask

  task automatic t_partial();
    sendByte(8'hB1, 0);
    sendByte(8'hB2, 1);
    chk("R2 partial req", 32'(rxReq), 1);
    chk("R2 partial data", rxData, 32'h0000B1B2);
    chk("R2 partial count", 32'(rxHeadBytes), 2);
    popRx();
    rxFrameEnd = 1; step(); rxFrameEnd = 0;
    chk("R2 bare frame end stores nothing", 32'(fifoStatus[5:0]), 0);
    chk("R2 bare frame end no req", 32'(rxReq), 0);
    sendByte(8'hC1, 0);
    rxFrameEnd = 1; step(); rxFrameEnd = 0;
    chk("R2 end-only single byte", {rxHeadBytes, rxData[28:0]}, {3'd1, 29'h000000C1});
    popRx();
  endtask

  task automatic t_rx_trig();
    ctrlWrite(1, 16'h0201);
    for (int w = 0; w < 3; w++) begin
      for (int j = 0; j < 4; j++) sendByte(8'(w * 4 + j), 0);
      chk("R7 rx request on level", 32'(rxReq), (w == 1) ? 1 : 0);
    end
    chk("R3 rx level field", {16'd0, fifoStatus}, 32'h0000_0003);
    sendByte(8'hD1, 0);
    ctrlWrite(1, 16'h0203);
    chk("R5 rx flush empties", 32'(fifoStatus[5:0]), 0);
    sendByte(8'hE1, 0); sendByte(8'hE2, 0); sendByte(8'hE3, 0); sendByte(8'hE4, 0);
    chk("R5 packer cleared by flush", rxData, 32'hE1E2E3E4);
    chk("R5 flush bit not kept", 32'(fifoStatus[5:0]), 1);
    popRx();
  endtask

  task automatic t_disable();
    ctrlWrite(1, 16'h0000);
    sendByte(8'h11, 0); sendByte(8'h12, 0); sendByte(8'h13, 0); sendByte(8'h14, 1);
    chk("R4 rx disabled drops bytes", 32'(fifoStatus[5:0]), 0);
    pushTx(32'hDEADBEEF);
    chk("R4 tx disabled drops push", 32'(fifoStatus[13:8]), 0);
  endtask

  task automatic t_overflow();
    ctrlWrite(1, 16'h0001);
    for (int w = 0; w < 9; w++) begin
      for (int j = 0; j < 4; j++) sendByte(8'(w * 16 + j), 0);
    end
    chk("R9 overflow pulse", 32'(rxOverflow), 1);
    chk("R9 level stays full", 32'(fifoStatus[5:0]), 8);
    chk("R9 oldest kept", rxData, 32'h00010203);
    for (int k = 0; k < 7; k++) popRx();
    chk("R9 last stored entry", rxData, 32'h70717273);
    popRx();
    chk("R9 drained", 32'(fifoStatus[5:0]), 0);
  endtask

  task automatic t_tx();
    ctrlWrite(0, 16'h0101);
    pushTx(32'h11111111); pushTx(32'h22222222); pushTx(32'h33333333);
    chk("R11 tx level", {16'd0, fifoStatus}, 32'h0000_0300);
    chk("R11 tx head", txData, 32'h11111111);
    popTx(0);
    chk("R8 no req above trigger", 32'(txReq), 0);
    chk("R11 tx second", txData, 32'h22222222);
    popTx(0);
    chk("R8 req at trigger", 32'(txReq), 1);
    popTx(0);
    chk("R8 no req below trigger", 32'(txReq), 0);
    popTx(1);
    chk("R10 underflow when active", 32'(txUnderflow), 1);
    popTx(0);
    chk("R10 no underflow when idle", 32'(txUnderflow), 0);
    for (int k = 0; k < 5; k++) pushTx(32'(k + 1));
    chk("R11 full tx drops push", 32'(fifoStatus[13:8]), 4);
    chk("R11 head after full", txData, 32'h00000001);
    ctrlWrite(0, 16'h0103);
    chk("R5 tx flush empties", 32'(fifoStatus[13:8]), 0);
    chk("R8 req on flush", 32'(txReq), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    step();
    t_reset();
    t_pack();
    t_partial();
    t_rx_trig();
    t_disable();
    t_overflow();
    t_tx();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule